// File: doc/BRIEF.md
# Addressed Three-Wire Configuration Loader

This block takes configuration words for a dual-channel frequency synthesizer over a three-wire serial link made of a serial clock, a data line and a load-enable strobe. All three lines come from another clock domain. Two-flop synchronizers bring them into the system clock domain, and the block detects their edges there. On each rising serial-clock edge, the data bit is shifted into a 22-bit register, most significant bit first. The serial clock must run at no more than one quarter of the system clock rate.

A rising edge on load-enable commits the register to exactly one of four holding latches. The two bits shifted in last form the destination code. The latches hold a reference-divider value for each channel, and a feedback-divider value for each channel, which splits into a swallow field and a main-counter field. When a latch is written, it raises a one-cycle update strobe for its consumer.

Top module: `tw_cfg_loader`

## Requirements
- R1: After reset, every latched output is zero and no update strobe is active.
- R2: Data is captured on rising serial-clock edges, most significant bit first. When more than 22 bits arrive before a commit, only the last 22 bits count.
- R3: The destination code is word bits [1:0], where bit 1 is the earlier of the two final bits. Code 0 selects the channel-2 reference latch, 1 the channel-1 reference latch, 2 the channel-2 feedback latch and 3 the channel-1 feedback latch.
- R4: A reference latch receives word bits [16:2] as its 15-bit divide value. Word bits [21:17] have no effect on it.
- R5: A feedback latch receives word bits [8:2] as the 7-bit swallow value and word bits [19:9] as the 11-bit main value. Word bits [21:20] have no effect on it.
- R6: Latches that a commit does not select keep their values.
- R7: Each commit pulses only the update strobe of the selected latch, for exactly one system cycle. The strobe index equals the destination code.
- R8: Serial bits that arrive while load-enable is high are not shifted in.
- R9: A commit happens only on a rising edge of load-enable. Holding load-enable high produces no further writes, and a later rising edge commits the register contents again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_le | input | 1 | Load-enable strobe, asynchronous |
| ch1_ref_div | output | 15 | Channel-1 reference divide value |
| ch2_ref_div | output | 15 | Channel-2 reference divide value |
| ch1_swallow | output | 7 | Channel-1 feedback swallow value |
| ch1_main | output | 11 | Channel-1 feedback main-counter value |
| ch2_swallow | output | 7 | Channel-2 feedback swallow value |
| ch2_main | output | 11 | Channel-2 feedback main-counter value |
| upd_strobe | output | 4 | One-cycle write strobe per latch, indexed by destination code |

## Verification
The bench sends every destination code with several payload patterns, and it sets the unused top bits so that a wrong field slice gets caught. A design with swapped control-bit order or a wrong channel mapping would write into the wrong latch, and the unselected outputs would then change. An overlong frame catches a register that counts bits instead of shifting. A frame shifted while load-enable is high, followed by a second rising edge, catches a design that keeps shifting under load-enable or that commits on the level instead of the edge: it would either show the new word or count more than one strobe cycle.

// File: rtl/tw_cfg_pkg.sv
package tw_cfg_pkg;
    localparam int WORD_W = 22;
    localparam int CTRL_W = 2;
    localparam int REF_W  = 15;
    localparam int SWAL_W = 7;
    localparam int MAIN_W = 11;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [CTRL_W-1:0] {
        DEST_CH2_REF = 2'b00,
        DEST_CH1_REF = 2'b01,
        DEST_CH2_FB  = 2'b10,
        DEST_CH1_FB  = 2'b11
    } dest_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [STAGES-1:0][N-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/tw_shifter.sv
module tw_shifter #(
    parameter int WORD_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdat_s,
    input  logic              sle_s,
    output logic [WORD_W-1:0] word_o,
    output logic              load_o
);
    typedef struct packed {
        logic              sclk_prev;
        logic              le_prev;
        logic [WORD_W-1:0] sr;
        logic              load;
    } shift_t;

    shift_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        st_d.le_prev   = sle_s;
        st_d.load      = sle_s & ~st_q.le_prev;
        if (sclk_s && !st_q.sclk_prev && !sle_s) begin
            st_d.sr = {st_q.sr[WORD_W-2:0], sdat_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o = st_q.sr;
    assign load_o = st_q.load;

    // R8: while load-enable is high the register must not move
    assert_le_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sle_s |=> $stable(word_o));
    // R9: a commit request never lasts two cycles in a row
    assert_load_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);
endmodule

// File: rtl/tw_latch_bank.sv
module tw_latch_bank #(
    parameter int WORD_W = 22,
    parameter int CTRL_W = 2,
    parameter int REF_W  = 15,
    parameter int FB_W   = 18
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [WORD_W-1:0]             word_i,
    input  logic                          load_i,
    output logic [1:0][REF_W-1:0]         ref_o,
    output logic [1:0][FB_W-1:0]          fb_o,
    output logic [(2**CTRL_W)-1:0]        upd_o
);
    localparam int NDEST = 2 ** CTRL_W;
    localparam int NCH   = 2;

    typedef struct packed {
        logic [NCH-1:0][REF_W-1:0] ref_lat;
        logic [NCH-1:0][FB_W-1:0]  fb_lat;
        logic [NDEST-1:0]          upd;
    } bank_t;

    bank_t bk_d, bk_q;
    logic [CTRL_W-1:0] sel;
    logic unused_hi;

    assign sel       = word_i[CTRL_W-1:0];
    assign unused_hi = ^word_i[WORD_W-1:CTRL_W+FB_W];

    always_comb begin
        bk_d     = bk_q;
        bk_d.upd = '0;
        if (load_i) begin
            bk_d.upd[sel] = 1'b1;
            if (sel[CTRL_W-1]) bk_d.fb_lat[sel[0]]  = word_i[CTRL_W +: FB_W];
            else               bk_d.ref_lat[sel[0]] = word_i[CTRL_W +: REF_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign ref_o = bk_q.ref_lat;
    assign fb_o  = bk_q.fb_lat;
    assign upd_o = bk_q.upd;

    assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd_o));
    assert_load_gives_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> ($countones(upd_o) == 1));

    for (genvar i = 0; i < NDEST; i++) begin : g_chk
        localparam int CH = i % 2;
        if (i < 2) begin : g_ref
            assert_hold_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !upd_o[i] |-> $stable(ref_o[CH]));
            assert_ref_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
                upd_o[i] |-> (ref_o[CH] == $past(word_i[CTRL_W +: REF_W])));
        end else begin : g_fb
            assert_hold_fb_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !upd_o[i] |-> $stable(fb_o[CH]));
            assert_fb_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
                upd_o[i] |-> (fb_o[CH] == $past(word_i[CTRL_W +: FB_W])));
        end
    end
endmodule

// File: rtl/tw_cfg_loader.sv
module tw_cfg_loader
    import tw_cfg_pkg::*;
#(
    parameter int P_WORD_W = WORD_W,
    parameter int P_REF_W  = REF_W,
    parameter int P_SWAL_W = SWAL_W,
    parameter int P_MAIN_W = MAIN_W,
    parameter int P_STAGES = SYNC_STAGES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_clk,
    input  logic                ser_data,
    input  logic                ser_le,
    output logic [P_REF_W-1:0]  ch1_ref_div,
    output logic [P_REF_W-1:0]  ch2_ref_div,
    output logic [P_SWAL_W-1:0] ch1_swallow,
    output logic [P_MAIN_W-1:0] ch1_main,
    output logic [P_SWAL_W-1:0] ch2_swallow,
    output logic [P_MAIN_W-1:0] ch2_main,
    output logic [3:0]          upd_strobe
);
    localparam int FB_W = P_SWAL_W + P_MAIN_W;

    logic [2:0]              lines_s;
    logic [P_WORD_W-1:0]     word;
    logic                    load;
    logic [1:0][P_REF_W-1:0] ref_lat;
    logic [1:0][FB_W-1:0]    fb_lat;

    tw_sync #(.N(3), .STAGES(P_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({ser_le, ser_data, ser_clk}),
        .sync_o (lines_s)
    );

    tw_shifter #(.WORD_W(P_WORD_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk_s(lines_s[0]),
        .sdat_s(lines_s[1]),
        .sle_s (lines_s[2]),
        .word_o(word),
        .load_o(load)
    );

    tw_latch_bank #(
        .WORD_W(P_WORD_W), .CTRL_W(CTRL_W), .REF_W(P_REF_W), .FB_W(FB_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .word_i(word),
        .load_i(load),
        .ref_o (ref_lat),
        .fb_o  (fb_lat),
        .upd_o (upd_strobe)
    );

    // channel index 0 is channel 2, index 1 is channel 1 (low control bit)
    assign ch2_ref_div = ref_lat[0];
    assign ch1_ref_div = ref_lat[1];
    assign ch2_swallow = fb_lat[0][P_SWAL_W-1:0];
    assign ch2_main    = fb_lat[0][FB_W-1:P_SWAL_W];
    assign ch1_swallow = fb_lat[1][P_SWAL_W-1:0];
    assign ch1_main    = fb_lat[1][FB_W-1:P_SWAL_W];
endmodule

// File: tb/tw_cfg_loader_bench.sv
module tw_cfg_loader_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [14:0] ch1_ref_div, ch2_ref_div;
    logic [6:0]  ch1_swallow, ch2_swallow;
    logic [10:0] ch1_main, ch2_main;
    logic [3:0]  upd_strobe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int scnt [4];

    // model indexed by low control bit: 0 = channel 2, 1 = channel 1
    logic [14:0] m_ref  [2];
    logic [6:0]  m_swal [2];
    logic [10:0] m_main [2];

    always #10 clk = ~clk;

    tw_cfg_loader u_tw_cfg_loader (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .ch1_ref_div(ch1_ref_div), .ch2_ref_div(ch2_ref_div),
        .ch1_swallow(ch1_swallow), .ch1_main(ch1_main),
        .ch2_swallow(ch2_swallow), .ch2_main(ch2_main),
        .upd_strobe(upd_strobe)
    );

    always @(posedge clk) begin
        if (rst_n) for (int i = 0; i < 4; i++) scnt[i] += int'(upd_strobe[i]);
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_outs(string req);
        chk(req, "ch2_ref_div", int'(ch2_ref_div), int'(m_ref[0]));
        chk(req, "ch1_ref_div", int'(ch1_ref_div), int'(m_ref[1]));
        chk(req, "ch2_swallow", int'(ch2_swallow), int'(m_swal[0]));
        chk(req, "ch1_swallow", int'(ch1_swallow), int'(m_swal[1]));
        chk(req, "ch2_main",    int'(ch2_main),    int'(m_main[0]));
        chk(req, "ch1_main",    int'(ch1_main),    int'(m_main[1]));
    endtask

    task automatic check_strobes(string req, int dest);
        for (int i = 0; i < 4; i++)
            chk(req, $sformatf("strobe cycles[%0d]", i), scnt[i], (i == dest) ? 1 : 0);
    endtask

    task automatic clear_cnt();
        for (int i = 0; i < 4; i++) scnt[i] = 0;
    endtask

    task automatic send_bit(logic b);
        ser_data = b;
        repeat (4) @(negedge clk);
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    task automatic send_word(logic [21:0] w);
        for (int i = 21; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic pulse_le();
        repeat (2) @(negedge clk);
        ser_le = 1'b1;
        repeat (8) @(negedge clk);
        ser_le = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic model_commit(logic [21:0] w);
        if (w[1]) begin
            m_swal[w[0]] = w[8:2];
            m_main[w[0]] = w[19:9];
        end else begin
            m_ref[w[0]] = w[16:2];
        end
    endtask

    task automatic load_and_check(logic [21:0] w, string req);
        send_word(w);
        clear_cnt();
        pulse_le();
        model_commit(w);
        check_outs(req);
        check_strobes("R7", int'(w[1:0]));
    endtask

    function automatic logic [19:0] pattern(int k, int code);
        case (k)
            0: return 20'hFFFFF;
            1: return 20'h00000;
            2: return 20'hAAAAA;
            3: return 20'h55555;
            4: return 20'h00001 << (code * 5 + 1);
            5: return 20'h80000 >> (code * 3 + 2);
            default: return 20'((k * 32'h2F3B7 + code * 32'h1D1D) & 32'hFFFFF);
        endcase
    endfunction

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_ref[c] = '0; m_swal[c] = '0; m_main[c] = '0;
        end
        clear_cnt();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1: reset state
        check_outs("R1");
        check_strobes("R1", -1);

        // R3 R4 R5 R6: sweep every destination with patterns; top bits vary
        for (int k = 0; k < 8; k++) begin
            for (int code = 0; code < 4; code++) begin
                logic [1:0] hi;
                hi = 2'(k + code);
                load_and_check({hi, pattern(k, code), 2'(code)},
                               (code < 2) ? "R3/R4/R6" : "R3/R5/R6");
            end
        end

        // R4: reference word with bits [21:17] all set must ignore them
        load_and_check({5'b11111, 15'h1234, 2'b01}, "R4");
        // R5: feedback word with bits [21:20] set
        load_and_check({2'b11, 11'h5A3, 7'h2C, 2'b10}, "R5");

        // R2: overlong frame, only last 22 bits count
        for (int j = 0; j < 7; j++) send_bit(1'(j % 2));
        load_and_check({2'b01, 11'h3C5, 7'h4B, 2'b11}, "R2");

        // R8 and R9: commit A, then shift B while load-enable is high
        begin
            logic [21:0] wa, wb;
            wa = {2'b00, 11'h2D1, 7'h33, 2'b10};
            wb = {5'b0, 15'h7ABC, 2'b01};
            load_and_check(wa, "R8");
            clear_cnt();
            repeat (2) @(negedge clk);
            ser_le = 1'b1;
            send_word(wb);
            repeat (4) @(negedge clk);
            ser_le = 1'b0;
            repeat (8) @(negedge clk);
            // R9: long high level gives exactly one strobe cycle on A's latch
            check_strobes("R9", 2);
            check_outs("R8");
            // R9: a fresh rising edge recommits A; B never entered (R8)
            clear_cnt();
            pulse_le();
            check_outs("R8");
            check_strobes("R9", 2);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule